// File: doc/BRIEF.md
# Cache Miss Classification Unit

This block observes the lookups made to a small direct-mapped cache and gives each one an outcome. An outcome is a hit, or one of four kinds of miss. It keeps only cache metadata: a tag and a valid bit for each line, and a count of occupied lines. It also keeps a record of every block address seen since reset. It holds no data and performs no refill. After each miss it installs the new tag, so the metadata follows the contents a real cache would hold.

A miss is labelled in fixed priority order. The first access to a block since reset is compulsory. Otherwise, a miss while every line is valid is capacity. Otherwise, a miss that displaces a valid line is conflict. The remaining case is a fill: a block seen before lands in an invalid line without evicting anything, as happens after a flush. The outcome comes out one cycle after the access as a one-hot kind vector with a valid pulse. Saturating counters keep a running tally of each outcome for profiling.

Top module: `cache_miss_classifier`

## Requirements
- R1: The block address is `acc_addr[ADDR_W-1:OFFSET_W]`. The line index is its low INDEX_W bits and the tag is the remaining upper bits. The offset bits never affect the outcome: two addresses that differ only in their offset hit the same line.
- R2: An access is a hit only when its line is valid and the stored tag equals the incoming tag. The outcome is reported on `res_kind` as a one-hot code: bit 0 hit, bit 1 compulsory, bit 2 capacity, bit 3 conflict, bit 4 fill. `res_hit` equals bit 0.
- R3: A miss on a block address not accessed since reset is compulsory. This holds even when the cache is full and the miss displaces a valid line.
- R4: A miss on a previously accessed block while all lines are valid is capacity.
- R5: A miss on a previously accessed block is conflict when at least one line is invalid and the indexed line holds a valid, different tag.
- R6: A miss on a previously accessed block whose indexed line is invalid is a fill. The line becomes valid and the count of occupied lines grows by one.
- R7: The outcome appears on `res_valid`/`res_kind` one cycle after the access strobe, for one cycle. With no strobe, `res_valid` is 0 and `res_kind` is 0.
- R8: `flush` invalidates every line and empties the occupancy count on the next edge, but keeps the first-touch record. An access presented in the same cycle as `flush` is dropped and produces no outcome.
- R9: Each outcome increments its own counter by one. Counters saturate at all ones and are not cleared by `flush`.
- R10: Reset clears all lines, the occupancy count, the first-touch record, the outputs and the counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe |
| acc_addr | input | ADDR_W | Byte address of the access |
| flush | input | 1 | Invalidate all lines |
| res_valid | output | 1 | Outcome valid pulse |
| res_hit | output | 1 | Outcome is a hit |
| res_kind | output | 5 | One-hot outcome code |
| cnt_hit | output | CNT_W | Hit tally |
| cnt_cold | output | CNT_W | Compulsory miss tally |
| cnt_cap | output | CNT_W | Capacity miss tally |
| cnt_conf | output | CNT_W | Conflict miss tally |
| cnt_fill | output | CNT_W | Fill miss tally |

## Verification
The bench builds the block with ADDR_W=10, OFFSET_W=2, INDEX_W=2 and CNT_W=3. With only four lines, the cache fills after four cold misses, so the compulsory-over-capacity priority and the capacity case appear after a handful of accesses. The 3-bit counters let a short run of repeated hits reach the saturation limit. The small tag field makes it easy to pick two blocks that share an index.

// File: rtl/cmc_pkg.sv
package cmc_pkg;
    // Outcome positions in the one-hot kind vector
    localparam int K_HIT   = 0;
    localparam int K_COLD  = 1;
    localparam int K_CAP   = 2;
    localparam int K_CONF  = 3;
    localparam int K_FILL  = 4;
    localparam int N_KINDS = 5;

    typedef logic [N_KINDS-1:0] kind_t;
endpackage

// File: rtl/cmc_tag_store.sv
module cmc_tag_store #(
    parameter int INDEX_W = 3,
    parameter int TAG_W   = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               fill_en,
    input  logic [INDEX_W-1:0] idx,
    input  logic [TAG_W-1:0]   tag,
    output logic               line_valid,
    output logic               tag_eq,
    output logic               full
);
    localparam int LINES = 1 << INDEX_W;
    localparam int OCC_W = INDEX_W + 1;

    typedef struct packed {
        logic [LINES-1:0]            valid;
        logic [LINES-1:0][TAG_W-1:0] tags;
        logic [OCC_W-1:0]            occ;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.valid = '0;
            st_d.occ   = '0;
        end else if (fill_en) begin
            if (!st_q.valid[idx]) st_d.occ = st_q.occ + 1'b1;
            st_d.valid[idx] = 1'b1;
            st_d.tags[idx]  = tag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign line_valid = st_q.valid[idx];
    assign tag_eq     = (st_q.tags[idx] == tag);
    assign full       = (st_q.occ == OCC_W'(LINES));
endmodule

// File: rtl/cmc_seen_map.sv
module cmc_seen_map #(
    parameter int BLK_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [BLK_W-1:0] blk,
    output logic             seen
);
    localparam int NBLK = 1 << BLK_W;

    logic [NBLK-1:0] bits_d, bits_q;

    always_comb begin
        bits_d = bits_q;
        if (set_en) bits_d[blk] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits_d;
    end

    assign seen = bits_q[blk];
endmodule

// File: rtl/cmc_classify.sv
module cmc_classify
    import cmc_pkg::*;
(
    input  logic  line_valid,
    input  logic  tag_eq,
    input  logic  seen,
    input  logic  full,
    output kind_t kind
);
    always_comb begin
        kind = '0;
        if (line_valid && tag_eq) kind[K_HIT]  = 1'b1;
        else if (!seen)           kind[K_COLD] = 1'b1;
        else if (full)            kind[K_CAP]  = 1'b1;
        else if (line_valid)      kind[K_CONF] = 1'b1;
        else                      kind[K_FILL] = 1'b1;
    end
endmodule

// File: rtl/cache_miss_classifier.sv
module cache_miss_classifier
    import cmc_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int OFFSET_W = 2,
    parameter int INDEX_W  = 3,
    parameter int CNT_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              flush,
    output logic              res_valid,
    output logic              res_hit,
    output logic [4:0]        res_kind,
    output logic [CNT_W-1:0]  cnt_hit,
    output logic [CNT_W-1:0]  cnt_cold,
    output logic [CNT_W-1:0]  cnt_cap,
    output logic [CNT_W-1:0]  cnt_conf,
    output logic [CNT_W-1:0]  cnt_fill
);
    localparam int BLK_W = ADDR_W - OFFSET_W;
    localparam int TAG_W = BLK_W - INDEX_W;

    typedef struct packed {
        logic                            vld;
        kind_t                           kind;
        logic [N_KINDS-1:0][CNT_W-1:0]   cnt;
    } out_t;

    out_t o_d, o_q;

    logic [BLK_W-1:0]   blk;
    logic [INDEX_W-1:0] idx;
    logic [TAG_W-1:0]   tag;
    logic               take;
    logic               line_valid, tag_eq, seen, full;
    kind_t              kind;

    assign blk  = acc_addr[ADDR_W-1:OFFSET_W];
    assign idx  = blk[INDEX_W-1:0];
    assign tag  = blk[BLK_W-1:INDEX_W];
    assign take = acc_valid && !flush;

    cmc_tag_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .fill_en    (take && !kind[K_HIT]),
        .idx        (idx),
        .tag        (tag),
        .line_valid (line_valid),
        .tag_eq     (tag_eq),
        .full       (full)
    );

    cmc_seen_map #(.BLK_W(BLK_W)) u_seen (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (take),
        .blk    (blk),
        .seen   (seen)
    );

    cmc_classify u_cls (
        .line_valid (line_valid),
        .tag_eq     (tag_eq),
        .seen       (seen),
        .full       (full),
        .kind       (kind)
    );

    always_comb begin
        o_d      = o_q;
        o_d.vld  = take;
        o_d.kind = take ? kind : '0;
        for (int k = 0; k < N_KINDS; k++) begin
            if (take && kind[k] && (o_q.cnt[k] != {CNT_W{1'b1}}))
                o_d.cnt[k] = o_q.cnt[k] + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign res_valid = o_q.vld;
    assign res_kind  = o_q.kind;
    assign res_hit   = o_q.kind[K_HIT];
    assign cnt_hit   = o_q.cnt[K_HIT];
    assign cnt_cold  = o_q.cnt[K_COLD];
    assign cnt_cap   = o_q.cnt[K_CAP];
    assign cnt_conf  = o_q.cnt[K_CONF];
    assign cnt_fill  = o_q.cnt[K_FILL];
endmodule

// File: rtl/cmc_checker.sv
module cmc_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_valid,
    input logic             flush,
    input logic             res_valid,
    input logic [4:0]       res_kind,
    input logic [CNT_W-1:0] cnt_hit,
    input logic [CNT_W-1:0] cnt_cold
);
    a_r7_result_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(acc_valid && !flush));

    a_r8_flush_drops_access: assert property (@(posedge clk) disable iff (!rst_n)
        $past(flush) |-> !res_valid);

    a_r2_kind_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ($countones(res_kind) == 1));

    a_r7_idle_kind_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (res_kind == '0));

    a_r9_hit_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_hit != $past(cnt_hit)) |->
            (res_valid && res_kind[0] && (cnt_hit == CNT_W'($past(cnt_hit) + 1'b1))));

    a_r9_cold_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_cold != $past(cnt_cold)) |->
            (res_valid && res_kind[1] && (cnt_cold == CNT_W'($past(cnt_cold) + 1'b1))));
endmodule

bind cache_miss_classifier cmc_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .flush     (flush),
    .res_valid (res_valid),
    .res_kind  (res_kind),
    .cnt_hit   (cnt_hit),
    .cnt_cold  (cnt_cold)
);

// File: tb/tb_cache_miss_classifier.sv
module tb_cache_miss_classifier;
    localparam int PERIOD   = 10;
    localparam int ADDR_W   = 10;
    localparam int OFFSET_W = 2;
    localparam int INDEX_W  = 2;
    localparam int CNT_W    = 3;

    localparam logic [4:0] HIT  = 5'b00001;
    localparam logic [4:0] COLD = 5'b00010;
    localparam logic [4:0] CAP  = 5'b00100;
    localparam logic [4:0] CONF = 5'b01000;
    localparam logic [4:0] FILL = 5'b10000;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              acc_valid;
    logic [ADDR_W-1:0] acc_addr;
    logic              flush;
    logic              res_valid, res_hit;
    logic [4:0]        res_kind;
    logic [CNT_W-1:0]  cnt_hit, cnt_cold, cnt_cap, cnt_conf, cnt_fill;

    int n_checks = 0;
    int n_fails  = 0;
    int exp_cnt [5];
    bit finished = 0;

    always #(PERIOD/2) clk = ~clk;

    cache_miss_classifier #(
        .ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W), .INDEX_W(INDEX_W), .CNT_W(CNT_W)
    ) dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .flush(flush), .res_valid(res_valid), .res_hit(res_hit), .res_kind(res_kind),
        .cnt_hit(cnt_hit), .cnt_cold(cnt_cold), .cnt_cap(cnt_cap),
        .cnt_conf(cnt_conf), .cnt_fill(cnt_fill)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_counters(input string req);
        check({req, " hit tally"},  int'(cnt_hit),  exp_cnt[0]);
        check({req, " cold tally"}, int'(cnt_cold), exp_cnt[1]);
        check({req, " cap tally"},  int'(cnt_cap),  exp_cnt[2]);
        check({req, " conf tally"}, int'(cnt_conf), exp_cnt[3]);
        check({req, " fill tally"}, int'(cnt_fill), exp_cnt[4]);
    endtask

    // One access; block is the 8-bit block address, off the byte offset
    task automatic access(input logic [7:0] block, input logic [1:0] off,
                          input logic [4:0] exp_kind, input string req);
        acc_valid = 1'b1;
        acc_addr  = {block, off};
        @(negedge clk);
        acc_valid = 1'b0;
        for (int k = 0; k < 5; k++)
            if (exp_kind[k] && exp_cnt[k] < 7) exp_cnt[k]++;
        check({req, " valid"}, int'(res_valid), 1);
        check({req, " kind"},  int'(res_kind),  int'(exp_kind));
        check({req, " hit"},   int'(res_hit),   int'(exp_kind == HIT));
        check_counters(req);
    endtask

    task automatic t_reset;
        check("R10 res_valid", int'(res_valid), 0);
        check("R10 res_kind",  int'(res_kind),  0);
        check_counters("R10");
    endtask

    task automatic t_cold;
        for (int b = 0; b < 4; b++) access(8'(b), 2'd0, COLD, "R3 first touch");
    endtask

    task automatic t_hit;
        access(8'd0, 2'd3, HIT, "R1 offset ignored");
        access(8'd2, 2'd1, HIT, "R2 hit");
        access(8'd3, 2'd2, HIT, "R2 hit");
    endtask

    task automatic t_full_cold_and_capacity;
        access(8'd4, 2'd0, COLD, "R3 cold over capacity");
        access(8'd0, 2'd0, CAP,  "R4 capacity");
        access(8'd4, 2'd1, CAP,  "R4 capacity");
        access(8'd1, 2'd0, HIT,  "R1 other lines kept");
    endtask

    task automatic t_idle;
        @(negedge clk);
        check("R7 no strobe valid", int'(res_valid), 0);
        check("R7 no strobe kind",  int'(res_kind),  0);
    endtask

    task automatic t_flush;
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        check("R8 flush no result", int'(res_valid), 0);
        check_counters("R8 counters kept");
        access(8'd4, 2'd0, FILL, "R8 R6 record kept");
        access(8'd0, 2'd0, CONF, "R5 conflict");
        access(8'd1, 2'd0, FILL, "R6 fill");
        access(8'd0, 2'd2, HIT,  "R2 after conflict");
    endtask

    task automatic t_flush_with_access;
        flush     = 1'b1;
        acc_valid = 1'b1;
        acc_addr  = {8'd0, 2'd0};
        @(negedge clk);
        flush     = 1'b0;
        acc_valid = 1'b0;
        check("R8 dropped access", int'(res_valid), 0);
        check_counters("R8 dropped access");
        access(8'd0, 2'd0, FILL, "R8 line was flushed");
    endtask

    task automatic t_saturate;
        for (int i = 0; i < 6; i++) access(8'd0, 2'd1, HIT, "R9 saturation");
        check("R9 hit tally at max", int'(cnt_hit), 7);
    endtask

    initial begin
        rst_n     = 1'b0;
        acc_valid = 1'b0;
        acc_addr  = '0;
        flush     = 1'b0;
        for (int k = 0; k < 5; k++) exp_cnt[k] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cold();
        t_hit();
        t_full_cold_and_capacity();
        t_idle();
        t_flush();
        t_flush_with_access();
        t_saturate();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #(PERIOD * 20000);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule